// File: doc/BRIEF.md
# Zero-Skipping Shifted Partial-Product Generator

This block forms the partial products of an unsigned N×N multiplication, one multiplier bit per cycle. When a start request is taken, the multiplicand, the multiplier and an approximation count are registered. The approximation count clears that many of the multiplier's low bits. The block then walks the masked multiplier from bit 0 upward, one bit per cycle. For every set bit it presents one partial product on a valid-qualified stream. That partial product is the multiplicand, zero-extended to 2N bits and shifted left by the bit's index. The bit index is carried next to it. A clear bit presents nothing, so a downstream adder tree only sees operands that contribute to the sum.

The shift is part of the same cycle that presents the operand, so it adds no latency. A whole operation takes N scan cycles plus one cycle for the completion flag. The number of partial products depends on the data. Dropping L low bits makes the work an N×(N−L) multiply: the result is approximate and there are fewer operands to add. The number of products emitted is reported and stays readable until the next start.

Top module: `pp_zero_skip_gen`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, pp_valid_o and done_o are 0 and pp_count_o is 0.
- R2: A start_i seen at a clock edge with busy_o low begins an operation. busy_o is 1 for the following N+1 cycles. done_o is 1 only in the last of those cycles, and busy_o is 0 in the cycle after it.
- R3: During the scan, cycle k (k = 0..N−1, counted from the start edge) handles multiplier bit k. pp_valid_o is 1 in that cycle exactly when bit k of the masked multiplier is 1, and pp_idx_o then equals k. Products therefore appear in ascending index order.
- R4: When pp_valid_o is 1, pp_data_o equals the registered multiplicand, zero-extended to 2N bits, shifted left by pp_idx_o.
- R5: The masked multiplier is the multiplier with bits 0..L−1 cleared, where L = min(mask_cnt_i, N). No product is emitted for an index below L.
- R6: pp_count_o is cleared when an operation starts and rises by one for each product emitted. When done_o is 1 it equals the number of ones in the masked multiplier, and it holds that value until the next start.
- R7: start_i while busy_o is 1 has no effect on the running operation.
- R8: A masked multiplier of zero produces no pp_valid_o pulse, but still completes after N+1 cycles with pp_count_o equal to 0.
- R9: The sum of all pp_data_o values of one operation equals the multiplicand times the masked multiplier.
- R10: mcand_i, mplier_i and mask_cnt_i are sampled only at the start edge. Changing them during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when not busy |
| mcand_i | input | N | Multiplicand |
| mplier_i | input | N | Multiplier |
| mask_cnt_i | input | $clog2(N+1) | Number of multiplier LSBs to clear |
| busy_o | output | 1 | Operation in progress |
| pp_valid_o | output | 1 | Partial product present |
| pp_data_o | output | 2N | Shifted partial product |
| pp_idx_o | output | $clog2(N) | Multiplier bit index of the product |
| pp_count_o | output | $clog2(N+1) | Products emitted in the current or last operation |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The assertions check several properties on every cycle:
- a product appears only while busy, and never below the clamped mask;
- its low pp_idx_o bits are zero;
- the scan index steps by one per scan cycle;
- done_o is a single pulse that follows the last index;
- the product count is cleared on each start.

Some behaviours can only be shown by the bench's scenarios. These are:
- that every set bit, and only set bits, produce a product with the right value;
- that the products sum to the masked multiply;
- that the count settles at the popcount;
- that a start, or operand changes, during a busy operation leave the result untouched.

// File: rtl/pp_gen_pkg.sv
package pp_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/pp_mask_unit.sv
module pp_mask_unit #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mplier_i,
  input  logic [CW-1:0] mask_cnt_i,
  output logic [N-1:0]  mplier_o,
  output logic [CW-1:0] lim_o
);
  localparam logic [CW-1:0] NMAX = CW'(N);

  // clamp to N so an oversize count clears the whole multiplier
  assign lim_o = (mask_cnt_i > NMAX) ? NMAX : mask_cnt_i;

  for (genvar g = 0; g < N; g++) begin : g_keep
    assign mplier_o[g] = mplier_i[g] & (lim_o <= CW'(g));
  end
endmodule

// File: rtl/pp_shift_unit.sv
module pp_shift_unit #(
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter int PW = 2 * N
) (
  input  logic [N-1:0]  mcand_i,
  input  logic [IW-1:0] sh_i,
  output logic [PW-1:0] pp_o
);
  logic [PW-1:0] stg [IW+1];

  assign stg[0] = {{(PW-N){1'b0}}, mcand_i};

  // log-depth barrel: stage s moves by 2**s when sh_i[s] is set
  for (genvar s = 0; s < IW; s++) begin : g_stage
    assign stg[s+1] = sh_i[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign pp_o = stg[IW];
endmodule

// File: rtl/pp_scan_ctrl.sv
module pp_scan_ctrl
  import pp_gen_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          scan_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  scan_state_e   state_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: if (idx_q == LAST) state_q <= ST_DONE;
                 else idx_q <= idx_q + 1'b1;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign scan_o   = (state_q == ST_SCAN);
  assign done_o   = (state_q == ST_DONE);
  assign accept_o = start_i && (state_q == ST_IDLE);
  assign idx_o    = idx_q;

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_o && $past(scan_o)) |-> (idx_q == $past(idx_q) + 1'b1));

  p_done_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(scan_o) && $past(idx_q) == LAST));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pp_zero_skip_gen.sv
module pp_zero_skip_gen #(
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1),
  parameter int PW = 2 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  mcand_i,
  input  logic [N-1:0]  mplier_i,
  input  logic [CW-1:0] mask_cnt_i,
  output logic          busy_o,
  output logic          pp_valid_o,
  output logic [PW-1:0] pp_data_o,
  output logic [IW-1:0] pp_idx_o,
  output logic [CW-1:0] pp_count_o,
  output logic          done_o
);
  logic          accept;
  logic          scan;
  logic [IW-1:0] idx;
  logic [N-1:0]  masked;
  logic [CW-1:0] lim;
  logic [N-1:0]  mcand_q;
  logic [N-1:0]  mplier_q;
  logic [CW-1:0] mask_q;
  logic [CW-1:0] count_q;

  pp_scan_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .scan_o   (scan),
    .done_o   (done_o),
    .idx_o    (idx)
  );

  pp_mask_unit #(.N(N), .CW(CW)) u_mask (
    .mplier_i   (mplier_i),
    .mask_cnt_i (mask_cnt_i),
    .mplier_o   (masked),
    .lim_o      (lim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      mask_q   <= '0;
      count_q  <= '0;
    end else if (accept) begin
      mcand_q  <= mcand_i;
      mplier_q <= masked;
      mask_q   <= lim;
      count_q  <= '0;
    end else if (pp_valid_o) begin
      count_q  <= count_q + 1'b1;
    end
  end

  // sensed multiplier bit gates the copy; shift rides along with it
  assign pp_valid_o = scan && mplier_q[idx];
  assign pp_idx_o   = idx;
  assign pp_count_o = count_q;

  pp_shift_unit #(.N(N), .IW(IW), .PW(PW)) u_shift (
    .mcand_i (mcand_q),
    .sh_i    (idx),
    .pp_o    (pp_data_o)
  );

  p_valid_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_valid_o |-> busy_o);

  p_above_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_valid_o |-> (CW'(pp_idx_o) >= mask_q));

  p_shift_zeros_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_valid_o |-> (((pp_data_o >> pp_idx_o) << pp_idx_o) == pp_data_o));

  p_count_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (pp_count_o == '0));

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_count_o <= CW'(N));
endmodule

// File: tb/pp_zero_skip_gen_tb.sv
module pp_zero_skip_gen_tb;
  localparam int N  = 16;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  mcand_i = '0;
  logic [N-1:0]  mplier_i = '0;
  logic [CW-1:0] mask_cnt_i = '0;
  logic          busy_o, pp_valid_o, done_o;
  logic [PW-1:0] pp_data_o;
  logic [IW-1:0] pp_idx_o;
  logic [CW-1:0] pp_count_o;

  always #10 clk = ~clk;

  pp_zero_skip_gen #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .mask_cnt_i(mask_cnt_i),
    .busy_o(busy_o), .pp_valid_o(pp_valid_o), .pp_data_o(pp_data_o),
    .pp_idx_o(pp_idx_o), .pp_count_o(pp_count_o), .done_o(done_o)
  );

  typedef struct packed { logic [PW-1:0] data; logic [IW-1:0] idx; } pp_item_t;
  typedef struct packed { logic [CW-1:0] cnt; logic [PW-1:0] prod; } op_item_t;

  pp_item_t      pp_q[$];
  op_item_t      op_q[$];
  int            total = 0;
  int            bad = 0;
  bit            finished = 0;
  logic [PW-1:0] sum_acc = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pp_valid_o) begin
        if (pp_q.size() == 0) begin
          check(0, "R3", "unexpected product idx", longint'(pp_idx_o), -1);
        end else begin
          pp_item_t e;
          e = pp_q.pop_front();
          check(pp_idx_o == e.idx, "R3", "product index", longint'(pp_idx_o), longint'(e.idx));
          check(pp_data_o == e.data, "R4", "product value", longint'(pp_data_o), longint'(e.data));
        end
        sum_acc = sum_acc + pp_data_o;
      end
      if (done_o) begin
        if (op_q.size() == 0) begin
          check(0, "R2", "done with no operation", 1, 0);
        end else begin
          op_item_t o;
          o = op_q.pop_front();
          check(pp_count_o == o.cnt, "R6", "count at done", longint'(pp_count_o), longint'(o.cnt));
          check(sum_acc == o.prod, "R9", "sum of products", longint'(sum_acc), longint'(o.prod));
          check(pp_q.size() == 0, "R3", "missing products", longint'(pp_q.size()), 0);
        end
        sum_acc = '0;
      end
    end
  end

  // driver: computes expectations from the requirements and runs one operation
  task automatic run_op(logic [N-1:0] mc, logic [N-1:0] mp, logic [CW-1:0] mk,
                        bit poke, string tag);
    int            lim;
    logic [N-1:0]  msk;
    int            c;
    op_item_t      o;
    lim = (int'(mk) > N) ? N : int'(mk);
    msk = mp;
    for (int i = 0; i < lim; i++) msk[i] = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (msk[i]) begin
        pp_item_t it;
        it.data = PW'(mc) << i;
        it.idx  = IW'(i);
        pp_q.push_back(it);
      end
    end
    o.cnt  = CW'($countones(msk));
    o.prod = PW'(mc) * PW'(msk);
    op_q.push_back(o);

    @(negedge clk);
    start_i = 1'b1; mcand_i = mc; mplier_i = mp; mask_cnt_i = mk;
    @(posedge clk);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 1) begin
        check(busy_o == 1'b1, "R2", "busy after start", longint'(busy_o), 1);
        start_i = poke;
        if (poke) begin
          mcand_i = ~mc; mplier_i = ~mp; mask_cnt_i = '0;
        end
      end else if (c == 2) begin
        start_i = 1'b0;
      end
    end while (!done_o && c < 3 * N);
    check(c == N + 1, "R2", "cycles to done", longint'(c), longint'(N + 1));
    @(negedge clk);
    check(busy_o == 1'b0, "R2", "idle after done", longint'(busy_o), 0);
    check(pp_count_o == o.cnt, tag, "count held after done", longint'(pp_count_o), longint'(o.cnt));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35;
    check(busy_o == 0 && pp_valid_o == 0 && done_o == 0 && pp_count_o == 0,
          "R1", "outputs in reset", {busy_o, pp_valid_o, done_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && pp_valid_o == 0 && done_o == 0 && pp_count_o == 0,
          "R1", "outputs after reset", {busy_o, pp_valid_o, done_o}, 0);

    run_op(16'hBEEF, 16'hA5C3, 5'd0,  0, "R6");
    run_op(16'h1234, 16'hFFFF, 5'd0,  0, "R6");   // worst case: N products
    run_op(16'hFFFF, 16'h0000, 5'd0,  0, "R8");   // nothing emitted
    run_op(16'h00FF, 16'hFFFF, 5'd4,  0, "R5");   // low four bits cleared
    run_op(16'h7001, 16'hFFFF, 5'd20, 0, "R5");   // clamped mask clears all
    run_op(16'h0F0F, 16'h8001, 5'd16, 0, "R5");
    run_op(16'h0001, 16'h0001, 5'd1,  0, "R8");   // only set bit masked
    run_op(16'hFFFF, 16'h8000, 5'd0,  0, "R4");   // top index
    run_op(16'h5A5A, 16'h3C69, 5'd3,  1, "R7/R10");
    for (int k = 0; k < 25; k++) begin
      run_op(N'($urandom), N'($urandom), CW'($urandom_range(0, N + 2)), bit'(k % 3 == 0), "R6");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule